// File: doc/BRIEF.md
# Dual-Window Short I/O Address Decoder

This block sits on the slave side of a VMEbus A16 short I/O port. It gives the host two separate views into one shared on-board memory. Each view, or window, has a base address and a size, both set by static strap inputs. The block only answers bus cycles and never starts one.

On each bus cycle the decoder checks three things: the address modifier, the address strobe, and the data strobe/longword shape of the transfer. It then reports a live hit. When a cycle hits, it latches the window number, the byte offset, the byte-lane enables and the write flag, and it raises a request toward the shared RAM port. After the RAM reports ready, the block drives the bus acknowledge and holds it until the host releases the address strobe.

The primary window is normally switched off, so the host reaches the memory through the secondary window alone. Each window has its own strap that widens the set of accepted address modifier codes.

Top module: `sioWindowDecoder`

## Requirements
- R1: After reset, ramReq and ack are both 0.
- R2: The window size strap maps 0, 1, 2 and 3 to 256, 512, 1024 and 2048 bytes. The latched ramOffset is the byte address modulo the window size.
- R3: A window matches when the byte address, divided by the window size, equals the base address ({base, 8'h00}) divided by the same size. Base bits below the window size have no effect.
- R4: Code 0x2D is always accepted. Code 0x29 is accepted only when that window's wide-modifier strap is 1. Any other code gives no hit.
- R5: With priEnable at 0, the primary window never hits.
- R6: When both windows match, the secondary window wins and winSel is 1. A primary-only match gives winSel 0.
- R7: dataStb bit 1 is the even byte and bit 0 is the odd byte. The byte address is {addrBus, 1'b1} for an odd-only access and {addrBus, 1'b0} otherwise. byteEn bit k enables lane k:
  - even byte: lane {addrBus[1], 0}
  - odd byte: lane {addrBus[1], 1}
  - 16-bit: lanes 1:0 when addrBus[1] is 0, lanes 3:2 when it is 1
  - 32-bit (longWord with both strobes): all four lanes
- R8: These transfer shapes never hit:
  - no data strobe
  - longWord with a single data strobe
  - longWord with addrBus[1] at 1
- R9: While addrStb is 0, hit is 0 and no RAM request starts.
- R10: A hit seen at a clock edge while idle raises ramReq in the next cycle. During the request, winSel, ramOffset, byteEn and ramWrite hold the values of the hitting access.
- R11: ack rises one clock after ramRdy is sampled high during a request, and ramReq drops in that same cycle. ack stays high while addrStb stays high.
- R12: A clock edge that samples addrStb at 0 clears ramReq and ack in the next cycle. This also holds when the cycle is abandoned before the RAM is ready, and in that case no ack appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrBus | input | 15 | Bus address bits 15:1 |
| addrMod | input | 6 | Address modifier code |
| addrStb | input | 1 | Address strobe, active high |
| dataStb | input | 2 | Data strobes: bit 1 even byte, bit 0 odd byte |
| longWord | input | 1 | 32-bit transfer request |
| writeReq | input | 1 | 1 for a write cycle |
| ramRdy | input | 1 | Shared RAM ready |
| priEnable | input | 1 | Primary window enable strap |
| priSize | input | 2 | Primary window size strap |
| priBase | input | 8 | Primary base address bits 15:8 |
| priAmWide | input | 1 | Primary accepts 0x29 as well as 0x2D |
| secSize | input | 2 | Secondary window size strap |
| secBase | input | 8 | Secondary base address bits 15:8 |
| secAmWide | input | 1 | Secondary accepts 0x29 as well as 0x2D |
| hit | output | 1 | Live decode hit |
| winSel | output | 1 | Latched window: 0 primary, 1 secondary |
| ramOffset | output | 11 | Latched byte offset within the window |
| byteEn | output | 4 | Latched byte-lane enables |
| ramWrite | output | 1 | Latched write flag |
| ramReq | output | 1 | Request to the shared RAM |
| ack | output | 1 | Bus acknowledge |

## Verification
The hardest case to reach from the ports is a cycle that lands in the overlap of both windows when the two sizes differ and the base straps carry stray low bits. Here the secondary priority and the size masking act together. Random addresses rarely land in such an overlap, so the stimulus places each address inside a chosen window and re-randomises the straps on every access. Directed cases then force an overlap, an abandoned request and a long-held acknowledge.

// File: rtl/sioDecoderPkg.sv
package sioDecoderPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2
  } sioState_t;

  typedef struct packed {
    logic capture;
    logic ramReq;
    logic ack;
  } sioCtl_t;
endpackage

// File: rtl/sioWindowMatch.sv
module sioWindowMatch #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  parameter int SIZE_SEL_W = 2,
  parameter int AM_W       = 6,
  parameter int OFF_W      = 11,
  parameter int BASE_W     = 8,
  parameter logic [AM_W-1:0] AM_STRICT = 6'h2D,
  parameter logic [AM_W-1:0] AM_EXTRA  = 6'h29
) (
  input  logic [ADDR_W-1:0]     byteAddr,
  input  logic [AM_W-1:0]       addrMod,
  input  logic                  enable,
  input  logic [SIZE_SEL_W-1:0] sizeSel,
  input  logic [BASE_W-1:0]     base,
  input  logic                  amWide,
  output logic                  match,
  output logic [OFF_W-1:0]      offset
);
  logic [BASE_W-1:0] ignoreMask;
  logic [OFF_W-1:0]  offMask;
  logic              amOk;

  always_comb begin
    ignoreMask = (BASE_W'(1) << sizeSel) - BASE_W'(1);
    offMask    = (OFF_W'(1) << (PAGE_W + int'(sizeSel))) - OFF_W'(1);
    amOk       = (addrMod == AM_STRICT) || (amWide && (addrMod == AM_EXTRA));
    match      = enable && amOk &&
                 (((byteAddr[ADDR_W-1:PAGE_W] ^ base) & ~ignoreMask) == '0);
    offset     = byteAddr[OFF_W-1:0] & offMask;
  end
endmodule

// File: rtl/sioDatapath.sv
module sioDatapath
  import sioDecoderPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  parameter int SIZE_SEL_W = 2,
  parameter int AM_W       = 6,
  parameter int OFF_W      = 11,
  parameter int BASE_W     = 8,
  parameter int NUM_WIN    = 2,
  parameter int LANES      = 4,
  parameter logic [AM_W-1:0] AM_STRICT = 6'h2D,
  parameter logic [AM_W-1:0] AM_EXTRA  = 6'h29
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [ADDR_W-1:1]                   addrBus,
  input  logic [AM_W-1:0]                     addrMod,
  input  logic                                addrStb,
  input  logic [1:0]                          dataStb,
  input  logic                                longWord,
  input  logic                                writeReq,
  input  logic [NUM_WIN-1:0]                  winEnable,
  input  logic [NUM_WIN-1:0][SIZE_SEL_W-1:0]  winSize,
  input  logic [NUM_WIN-1:0][BASE_W-1:0]      winBase,
  input  logic [NUM_WIN-1:0]                  winAmWide,
  input  sioCtl_t                             ctl,
  output logic                                hit,
  output logic                                winSel,
  output logic [OFF_W-1:0]                    ramOffset,
  output logic [LANES-1:0]                    byteEn,
  output logic                                ramWrite
);
  logic [ADDR_W-1:0]             byteAddr;
  logic                          oddOnly;
  logic                          shapeOk;
  logic [1:0]                    laneBase;
  logic [LANES-1:0]              laneNext;
  logic [NUM_WIN-1:0]            winMatch;
  logic [NUM_WIN-1:0][OFF_W-1:0] winOff;
  logic                          selHigh;

  assign oddOnly  = (dataStb == 2'b01);
  assign byteAddr = {addrBus, oddOnly};
  assign laneBase = {addrBus[1], oddOnly};

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    sioWindowMatch #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE_SEL_W(SIZE_SEL_W), .AM_W(AM_W),
      .OFF_W(OFF_W), .BASE_W(BASE_W), .AM_STRICT(AM_STRICT), .AM_EXTRA(AM_EXTRA)
    ) uMatch (
      .byteAddr(byteAddr),
      .addrMod (addrMod),
      .enable  (winEnable[w]),
      .sizeSel (winSize[w]),
      .base    (winBase[w]),
      .amWide  (winAmWide[w]),
      .match   (winMatch[w]),
      .offset  (winOff[w])
    );
  end

  always_comb begin
    shapeOk = (dataStb != 2'b00) &&
              (!longWord || ((dataStb == 2'b11) && !addrBus[1]));
    unique case ({longWord, dataStb})
      3'b010, 3'b001: laneNext = LANES'(1) << laneBase;
      3'b011:         laneNext = LANES'(2'b11) << laneBase;
      3'b111:         laneNext = '1;
      default:        laneNext = '0;
    endcase
    hit     = addrStb && shapeOk && (|winMatch);
    selHigh = winMatch[NUM_WIN-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winSel    <= 1'b0;
      ramOffset <= '0;
      byteEn    <= '0;
      ramWrite  <= 1'b0;
    end else if (ctl.capture) begin
      winSel    <= selHigh;
      ramOffset <= selHigh ? winOff[NUM_WIN-1] : winOff[0];
      byteEn    <= laneNext;
      ramWrite  <= writeReq;
    end
  end
endmodule

// File: rtl/sioControl.sv
module sioControl
  import sioDecoderPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hit,
  input  logic    addrStb,
  input  logic    ramRdy,
  output sioCtl_t ctl
);
  sioState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (hit) stateNext = ST_REQ;
      ST_REQ: begin
        if (!addrStb)    stateNext = ST_IDLE;
        else if (ramRdy) stateNext = ST_ACK;
      end
      ST_ACK:  if (!addrStb) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    ctl.capture = (state == ST_IDLE) && hit;
    ctl.ramReq  = (state == ST_REQ);
    ctl.ack     = (state == ST_ACK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/sioWindowDecoder.sv
module sioWindowDecoder
  import sioDecoderPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 8,
  parameter int SIZE_SEL_W = 2,
  parameter int AM_W       = 6,
  parameter int LANES      = 4,
  parameter logic [AM_W-1:0] AM_STRICT = 6'h2D,
  parameter logic [AM_W-1:0] AM_EXTRA  = 6'h29,
  localparam int BASE_W    = ADDR_W - PAGE_W,
  localparam int OFF_W     = PAGE_W + (1 << SIZE_SEL_W) - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:1]     addrBus,
  input  logic [AM_W-1:0]       addrMod,
  input  logic                  addrStb,
  input  logic [1:0]            dataStb,
  input  logic                  longWord,
  input  logic                  writeReq,
  input  logic                  ramRdy,
  input  logic                  priEnable,
  input  logic [SIZE_SEL_W-1:0] priSize,
  input  logic [BASE_W-1:0]     priBase,
  input  logic                  priAmWide,
  input  logic [SIZE_SEL_W-1:0] secSize,
  input  logic [BASE_W-1:0]     secBase,
  input  logic                  secAmWide,
  output logic                  hit,
  output logic                  winSel,
  output logic [OFF_W-1:0]      ramOffset,
  output logic [LANES-1:0]      byteEn,
  output logic                  ramWrite,
  output logic                  ramReq,
  output logic                  ack
);
  sioCtl_t ctl;

  sioDatapath #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SIZE_SEL_W(SIZE_SEL_W), .AM_W(AM_W),
    .OFF_W(OFF_W), .BASE_W(BASE_W), .NUM_WIN(2), .LANES(LANES),
    .AM_STRICT(AM_STRICT), .AM_EXTRA(AM_EXTRA)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .addrBus  (addrBus),
    .addrMod  (addrMod),
    .addrStb  (addrStb),
    .dataStb  (dataStb),
    .longWord (longWord),
    .writeReq (writeReq),
    .winEnable({1'b1, priEnable}),
    .winSize  ({secSize, priSize}),
    .winBase  ({secBase, priBase}),
    .winAmWide({secAmWide, priAmWide}),
    .ctl      (ctl),
    .hit      (hit),
    .winSel   (winSel),
    .ramOffset(ramOffset),
    .byteEn   (byteEn),
    .ramWrite (ramWrite)
  );

  sioControl uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .hit    (hit),
    .addrStb(addrStb),
    .ramRdy (ramRdy),
    .ctl    (ctl)
  );

  assign ramReq = ctl.ramReq;
  assign ack    = ctl.ack;
endmodule

// File: rtl/sioDecoderChecker.sv
module sioDecoderChecker #(
  parameter int OFF_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             addrStb,
  input logic             ramRdy,
  input logic             hit,
  input logic             ramReq,
  input logic             ack,
  input logic             winSel,
  input logic [OFF_W-1:0] ramOffset
);
  a_r9_no_strobe_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !addrStb |-> !hit);

  a_r12_strobe_low_release: assert property (@(posedge clk) disable iff (!rstN)
    !addrStb |=> (!ramReq && !ack));

  a_r11_ack_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    (ramReq && ramRdy && addrStb) |=> (ack && !ramReq));

  a_r11_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ack && addrStb) |=> ack);

  a_r10_request_from_hit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramReq) |-> $past(hit));

  a_r10_latched_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ramReq && addrStb && !ramRdy) |=> (ramReq && $stable(ramOffset) && $stable(winSel)));

  a_r11_req_ack_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ramReq && ack));
endmodule

bind sioWindowDecoder sioDecoderChecker #(.OFF_W(OFF_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .addrStb  (addrStb),
  .ramRdy   (ramRdy),
  .hit      (hit),
  .ramReq   (ramReq),
  .ack      (ack),
  .winSel   (winSel),
  .ramOffset(ramOffset)
);

// File: tb/tb_sioWindowDecoder.sv
module tb_sioWindowDecoder;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:1] addrBus = '0;
  logic [5:0]  addrMod = '0;
  logic        addrStb = 1'b0;
  logic [1:0]  dataStb = 2'b00;
  logic        longWord = 1'b0;
  logic        writeReq = 1'b0;
  logic        ramRdy = 1'b0;
  logic        priEnable = 1'b0;
  logic [1:0]  priSize = '0;
  logic [7:0]  priBase = '0;
  logic        priAmWide = 1'b0;
  logic [1:0]  secSize = '0;
  logic [7:0]  secBase = '0;
  logic        secAmWide = 1'b0;
  logic        hit, winSel, ramWrite, ramReq, ack;
  logic [10:0] ramOffset;
  logic [3:0]  byteEn;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sioWindowDecoder dut (
    .clk(clk), .rstN(rstN), .addrBus(addrBus), .addrMod(addrMod),
    .addrStb(addrStb), .dataStb(dataStb), .longWord(longWord),
    .writeReq(writeReq), .ramRdy(ramRdy), .priEnable(priEnable),
    .priSize(priSize), .priBase(priBase), .priAmWide(priAmWide),
    .secSize(secSize), .secBase(secBase), .secAmWide(secAmWide),
    .hit(hit), .winSel(winSel), .ramOffset(ramOffset), .byteEn(byteEn),
    .ramWrite(ramWrite), .ramReq(ramReq), .ack(ack)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit winHit(input logic [15:0] ba, input logic [5:0] am,
                                input bit en, input logic [1:0] sz,
                                input logic [7:0] bs, input bit wide);
    int bytes = 256 << sz;
    int baseA = int'(bs) * 256;
    bit amOk  = (am == 6'h2D) || (wide && am == 6'h29);
    return en && amOk && ((int'(ba) / bytes) == (baseA / bytes));
  endfunction

  task automatic refDecode(input logic [15:1] a, input logic [5:0] am,
                           input logic [1:0] ds, input bit lw,
                           output bit eHit, output bit eWin,
                           output logic [10:0] eOff, output logic [3:0] eBe);
    logic [15:0] ba;
    bit shape, mP, mS;
    ba = {a, (ds == 2'b01)};
    shape = (ds != 2'b00) && (!lw || (ds == 2'b11 && !a[1]));
    mP = winHit(ba, am, priEnable, priSize, priBase, priAmWide);
    mS = winHit(ba, am, 1'b1, secSize, secBase, secAmWide);
    eHit = shape && (mP || mS);
    eWin = mS;
    eOff = 11'(int'(ba) % (256 << (mS ? secSize : priSize)));
    if (lw)              eBe = 4'hF;
    else if (ds == 2'b11) eBe = a[1] ? 4'b1100 : 4'b0011;
    else if (ds == 2'b10) eBe = a[1] ? 4'b0100 : 4'b0001;
    else                 eBe = a[1] ? 4'b1000 : 4'b0010;
  endtask

  task automatic runAccess(input logic [15:1] a, input logic [5:0] am,
                           input logic [1:0] ds, input bit lw, input bit wr,
                           input string req);
    bit eHit, eWin;
    logic [10:0] eOff;
    logic [3:0] eBe;
    refDecode(a, am, ds, lw, eHit, eWin, eOff, eBe);
    @(negedge clk);
    addrBus = a; addrMod = am; dataStb = ds; longWord = lw; writeReq = wr;
    addrStb = 1'b1;
    #1;
    check(hit == eHit, {req, " hit"}, 32'(hit), 32'(eHit));
    @(negedge clk);
    if (eHit) begin
      check(ramReq == 1'b1, "R10 request", 32'(ramReq), 1);
      check(winSel == eWin, {req, " R6 window"}, 32'(winSel), 32'(eWin));
      check(ramOffset == eOff, {req, " R2 offset"}, 32'(ramOffset), 32'(eOff));
      check(byteEn == eBe, {req, " R7 lanes"}, 32'(byteEn), 32'(eBe));
      check(ramWrite == wr, "R10 write flag", 32'(ramWrite), 32'(wr));
      ramRdy = 1'b1;
      @(negedge clk);
      ramRdy = 1'b0;
      check(ack == 1'b1 && ramReq == 1'b0, "R11 ack after ready",
            32'({ack, ramReq}), 32'(2'b10));
      @(negedge clk);
      check(ack == 1'b1, "R11 ack held", 32'(ack), 1);
    end else begin
      check(ramReq == 1'b0 && ack == 1'b0, {req, " no request"},
            32'({ramReq, ack}), 0);
    end
    addrStb = 1'b0; dataStb = 2'b00; longWord = 1'b0;
    @(negedge clk);
    check(ack == 1'b0 && ramReq == 1'b0, "R12 release", 32'({ramReq, ack}), 0);
  endtask

  task automatic setStraps(input bit pe, input logic [1:0] ps, input logic [7:0] pb,
                           input bit pw, input logic [1:0] ss, input logic [7:0] sb,
                           input bit sw);
    priEnable = pe; priSize = ps; priBase = pb; priAmWide = pw;
    secSize = ss; secBase = sb; secAmWide = sw;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ramReq == 1'b0 && ack == 1'b0, "R1 reset state", 32'({ramReq, ack}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ramReq == 1'b0 && ack == 1'b0, "R1 after reset", 32'({ramReq, ack}), 0);

    // Secondary only, 2 KiB at 0x4000
    setStraps(1'b0, 2'd0, 8'h00, 1'b0, 2'd3, 8'h40, 1'b0);
    runAccess(15'h2000 | 15'h0123, 6'h2D, 2'b10, 1'b0, 1'b1, "R2");
    runAccess(15'h2000 | 15'h0123, 6'h2D, 2'b01, 1'b0, 1'b0, "R7");
    runAccess(15'h2000 | 15'h0011, 6'h2D, 2'b11, 1'b0, 1'b0, "R7");
    runAccess(15'h2000 | 15'h0010, 6'h2D, 2'b11, 1'b1, 1'b1, "R7");
    runAccess(15'h2400, 6'h2D, 2'b11, 1'b0, 1'b0, "R2 beyond window");
    // R3: stray low base bits ignored
    setStraps(1'b0, 2'd0, 8'h00, 1'b0, 2'd3, 8'h47, 1'b0);
    runAccess(15'h2000 | 15'h03FF, 6'h2D, 2'b01, 1'b0, 1'b0, "R3");
    // R4: modifier filter
    runAccess(15'h2000, 6'h29, 2'b11, 1'b0, 1'b0, "R4 narrow rejects 0x29");
    setStraps(1'b0, 2'd0, 8'h00, 1'b0, 2'd3, 8'h40, 1'b1);
    runAccess(15'h2000, 6'h29, 2'b11, 1'b0, 1'b0, "R4 wide accepts 0x29");
    runAccess(15'h2000, 6'h3D, 2'b11, 1'b0, 1'b0, "R4 other code");
    // R5: primary disabled
    setStraps(1'b0, 2'd1, 8'h10, 1'b1, 2'd0, 8'hF0, 1'b0);
    runAccess(15'h0800, 6'h2D, 2'b11, 1'b0, 1'b0, "R5 disabled");
    setStraps(1'b1, 2'd1, 8'h10, 1'b1, 2'd0, 8'hF0, 1'b0);
    runAccess(15'h0800 | 15'h00C0, 6'h29, 2'b10, 1'b0, 1'b0, "R5 enabled R6 primary");
    // R6: overlap, secondary wins
    setStraps(1'b1, 2'd3, 8'h00, 1'b0, 2'd0, 8'h03, 1'b0);
    runAccess(15'h0180, 6'h2D, 2'b11, 1'b0, 1'b0, "R6 overlap");
    // R8: illegal shapes
    runAccess(15'h0180, 6'h2D, 2'b00, 1'b0, 1'b0, "R8 no data strobe");
    runAccess(15'h0180, 6'h2D, 2'b10, 1'b1, 1'b0, "R8 lw single strobe");
    runAccess(15'h0181, 6'h2D, 2'b11, 1'b1, 1'b0, "R8 lw misaligned");

    // R9: no strobe, no hit, no request
    @(negedge clk);
    addrBus = 15'h0180; addrMod = 6'h2D; dataStb = 2'b11; addrStb = 1'b0;
    #1 check(hit == 1'b0, "R9 no strobe hit", 32'(hit), 0);
    @(negedge clk);
    check(ramReq == 1'b0, "R9 no strobe request", 32'(ramReq), 0);

    // R12: abandon before ready
    addrStb = 1'b1;
    @(negedge clk);
    check(ramReq == 1'b1, "R12 request started", 32'(ramReq), 1);
    addrStb = 1'b0;
    @(negedge clk);
    check(ramReq == 1'b0 && ack == 1'b0, "R12 abandon", 32'({ramReq, ack}), 0);
    ramRdy = 1'b1;
    @(negedge clk);
    ramRdy = 1'b0;
    check(ack == 1'b0, "R12 late ready ignored", 32'(ack), 0);

    // R11: long hold
    addrStb = 1'b1;
    @(negedge clk);
    ramRdy = 1'b1;
    @(negedge clk);
    ramRdy = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(ack == 1'b1, "R11 long hold", 32'(ack), 1);
      @(negedge clk);
    end
    addrStb = 1'b0;
    @(negedge clk);
    check(ack == 1'b0, "R11 release", 32'(ack), 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ps, ss, ds;
      logic [7:0] pb, sb;
      logic [15:1] a;
      logic [5:0] am;
      bit lw;
      int pick;
      ps = 2'($urandom); ss = 2'($urandom);
      pb = 8'($urandom); sb = 8'($urandom);
      setStraps(1'($urandom), ps, pb, 1'($urandom), ss, sb, 1'($urandom));
      pick = int'($urandom % 3);
      if (pick == 0)      a = 15'(({pb, 8'h00} + ($urandom % (256 << ps))) >> 1);
      else if (pick == 1) a = 15'(({sb, 8'h00} + ($urandom % (256 << ss))) >> 1);
      else                a = 15'($urandom);
      case ($urandom % 4)
        0: am = 6'h29;
        1: am = 6'($urandom);
        default: am = 6'h2D;
      endcase
      ds = 2'($urandom);
      lw = (($urandom % 4) == 0);
      runAccess(a, am, ds, lw, 1'($urandom), "R3 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule